// File: doc/BRIEF.md
# Recently-Charged Row Address Cache

This block sits beside the command path of a DRAM controller and remembers which rows were closed a short time ago. A row that has just been closed still holds nearly full cell charge, so reopening it soon afterwards can use shorter activation timings. Each precharge command writes the address of the row it closes into a small table. Each activate command looks up the row it opens. One cycle later the block returns the tRCD/tRAS pair that the bank timers must enforce: the reduced pair on a hit, the default pair on a miss.

Entries expire by age. A prescaled tick advances an age counter in every live entry. An entry is dropped when its age reaches a programmable limit, because by then the row's charge has leaked back to its normal level. A flush input empties the whole table in one cycle, for example when the device leaves self-refresh. The block schedules no commands and does not run the bank timers. It only supplies the timing values for each activate.

Top module: `charged_row_cache`

## Requirements
- R1: During and right after reset, timingValid and lookupHit are 0, tRcd reads 11 and tRas reads 28, and the table holds no entries.
- R2: timingValid is 1 in the cycle after an activate strobe and 0 in the cycle after any cycle without one; lookupHit is never 1 while timingValid is 0.
- R3: A lookup that finds no live matching entry gives lookupHit=0, tRcd=11, tRas=28.
- R4: A lookup that finds a live matching entry gives lookupHit=1, tRcd=7, tRas=20.
- R5: A precharge strobe, when no flush is present in that cycle, stores its address. An activate to that address in the next cycle hits.
- R6: The stored tag is the concatenation {rank, bank, row}. An address that differs only in rank, only in bank or only in row misses.
- R7: When a precharge and an activate arrive in the same cycle, the lookup sees the table as it was before that cycle's insertion.
- R8: A precharge to an address already in the table resets that entry's age to 0 and does not take a new slot.
- R9: New addresses go into slots in circular order starting at slot 0. Once the table is full, a new address replaces the entry allocated ENTRIES allocations earlier.
- R10: A tick occurs on every PRESCALE-th clock after reset. On each tick, every live entry's age increments, and an entry whose incremented age is at least expiryLimit is invalidated. An expired entry then misses. An insertion in the same cycle sets the age to 0 instead.
- R11: A flush strobe invalidates every entry and overrides any insertion in the same cycle. A lookup in the same cycle still sees the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| actStrobe | input | 1 | Activate command present |
| actRank | input | RANK_W | Rank of the row being opened |
| actBank | input | BANK_W | Bank of the row being opened |
| actRow | input | ROW_W | Row being opened |
| preStrobe | input | 1 | Precharge command present |
| preRank | input | RANK_W | Rank of the row being closed |
| preBank | input | BANK_W | Bank of the row being closed |
| preRow | input | ROW_W | Row being closed |
| flush | input | 1 | Invalidate every entry |
| expiryLimit | input | AGE_W | Age, in ticks, at which an entry expires |
| timingValid | output | 1 | Lookup result present (one cycle after activate) |
| lookupHit | output | 1 | Last lookup found a live entry |
| tRcd | output | TIME_W | Activate-to-column delay to enforce |
| tRas | output | TIME_W | Activate-to-precharge minimum to enforce |

## Verification
The bench builds the block with 4 entries, a prescale of 4 and 4-bit ages. These values make ring wrap-around, eviction of the earliest allocation and age expiry happen within tens of cycles. With narrow address fields (1-bit rank, 2-bit bank, 6-bit row), tags that differ in a single field are easy to produce. A random mix of precharge, activate and occasional flush over a small address pool keeps the 4-slot table under constant replacement pressure. The bench runs this mix with an expiry limit of 5 and runs directed sequences with limits of 3 and 15, so entries both expire and survive.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  // Per-cycle actions the control side asks of the entry store
  typedef struct packed {
    logic lookup;
    logic insert;
    logic flush;
    logic tick;
  } rccStrobe_t;
endpackage

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
#(
  parameter int PRESCALE = 1024,
  parameter int TIME_W   = 6,
  parameter int DEF_RCD  = 11,
  parameter int DEF_RAS  = 28,
  parameter int FAST_RCD = 7,
  parameter int FAST_RAS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              actStrobe,
  input  logic              preStrobe,
  input  logic              flush,
  input  logic              hitNow,
  output rccStrobe_t        strb,
  output logic              timingValid,
  output logic              lookupHit,
  output logic [TIME_W-1:0] tRcd,
  output logic [TIME_W-1:0] tRas
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] psCnt;
  logic            tickNow;

  assign tickNow = (psCnt == PS_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)        psCnt <= '0;
    else if (tickNow) psCnt <= '0;
    else              psCnt <= psCnt + 1'b1;
  end

  always_comb begin
    strb.lookup = actStrobe;
    strb.insert = preStrobe & ~flush;
    strb.flush  = flush;
    strb.tick   = tickNow;
  end

  // Registered result: one cycle after the activate strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timingValid <= 1'b0;
      lookupHit   <= 1'b0;
      tRcd        <= TIME_W'(DEF_RCD);
      tRas        <= TIME_W'(DEF_RAS);
    end else begin
      timingValid <= actStrobe;
      lookupHit   <= actStrobe & hitNow;
      if (actStrobe) begin
        tRcd <= hitNow ? TIME_W'(FAST_RCD) : TIME_W'(DEF_RCD);
        tRas <= hitNow ? TIME_W'(FAST_RAS) : TIME_W'(DEF_RAS);
      end
    end
  end
endmodule

// File: rtl/rcc_store.sv
module rcc_store
  import rcc_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int TAG_W   = 21,
  parameter int AGE_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rccStrobe_t       strb,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic [TAG_W-1:0] insertTag,
  input  logic [AGE_W-1:0] expiryLimit,
  output logic             hitNow
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [TAG_W-1:0] tagMem [ENTRIES];
  logic [AGE_W-1:0] ageQ   [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] lookMatch;
  logic [ENTRIES-1:0] insMatch;
  logic [PTR_W-1:0]   ptrQ;
  logic               insPresent;
  logic               doAlloc;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign lookMatch[i] = validQ[i] && (tagMem[i] == lookupTag);
    assign insMatch[i]  = validQ[i] && (tagMem[i] == insertTag);
  end

  assign hitNow     = |lookMatch;
  assign insPresent = |insMatch;
  assign doAlloc    = strb.insert && !insPresent;

  always_ff @(posedge clk) begin
    if (!rstN)        ptrQ <= '0;
    else if (doAlloc) ptrQ <= (ptrQ == PTR_LAST) ? '0 : ptrQ + 1'b1;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic             allocHere;
    logic             refreshHere;
    logic [AGE_W:0]   ageInc;

    assign allocHere   = doAlloc && (ptrQ == PTR_W'(i));
    assign refreshHere = strb.insert && insMatch[i];
    assign ageInc      = {1'b0, ageQ[i]} + (AGE_W+1)'(1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        ageQ[i]   <= '0;
      end else if (strb.flush) begin
        validQ[i] <= 1'b0;
      end else if (allocHere || refreshHere) begin
        validQ[i] <= 1'b1;
        ageQ[i]   <= '0;
      end else if (strb.tick && validQ[i]) begin
        if (ageInc >= {1'b0, expiryLimit}) validQ[i] <= 1'b0;
        else                               ageQ[i]   <= ageInc[AGE_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (allocHere) tagMem[i] <= insertTag;
    end
  end
endmodule

// File: rtl/charged_row_cache.sv
module charged_row_cache
  import rcc_pkg::*;
#(
  parameter int RANK_W   = 2,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 16,
  parameter int ENTRIES  = 128,
  parameter int AGE_W    = 8,
  parameter int PRESCALE = 1024,
  parameter int TIME_W   = 6,
  parameter int DEF_RCD  = 11,
  parameter int DEF_RAS  = 28,
  parameter int FAST_RCD = 7,
  parameter int FAST_RAS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              actStrobe,
  input  logic [RANK_W-1:0] actRank,
  input  logic [BANK_W-1:0] actBank,
  input  logic [ROW_W-1:0]  actRow,
  input  logic              preStrobe,
  input  logic [RANK_W-1:0] preRank,
  input  logic [BANK_W-1:0] preBank,
  input  logic [ROW_W-1:0]  preRow,
  input  logic              flush,
  input  logic [AGE_W-1:0]  expiryLimit,
  output logic              timingValid,
  output logic              lookupHit,
  output logic [TIME_W-1:0] tRcd,
  output logic [TIME_W-1:0] tRas
);
  localparam int TAG_W = RANK_W + BANK_W + ROW_W;

  rccStrobe_t       strb;
  logic             hitNow;
  logic [TAG_W-1:0] lookupTag;
  logic [TAG_W-1:0] insertTag;

  assign lookupTag = {actRank, actBank, actRow};
  assign insertTag = {preRank, preBank, preRow};

  rcc_ctrl #(
    .PRESCALE(PRESCALE), .TIME_W(TIME_W),
    .DEF_RCD(DEF_RCD), .DEF_RAS(DEF_RAS),
    .FAST_RCD(FAST_RCD), .FAST_RAS(FAST_RAS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .actStrobe(actStrobe), .preStrobe(preStrobe), .flush(flush),
    .hitNow(hitNow), .strb(strb),
    .timingValid(timingValid), .lookupHit(lookupHit),
    .tRcd(tRcd), .tRas(tRas)
  );

  rcc_store #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .AGE_W(AGE_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lookupTag(lookupTag), .insertTag(insertTag),
    .expiryLimit(expiryLimit), .hitNow(hitNow)
  );
endmodule

// File: rtl/charged_row_cache_chk.sv
module charged_row_cache_chk #(
  parameter int RANK_W   = 2,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 16,
  parameter int TIME_W   = 6,
  parameter int DEF_RCD  = 11,
  parameter int DEF_RAS  = 28,
  parameter int FAST_RCD = 7,
  parameter int FAST_RAS = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              actStrobe,
  input logic [RANK_W-1:0] actRank,
  input logic [BANK_W-1:0] actBank,
  input logic [ROW_W-1:0]  actRow,
  input logic              preStrobe,
  input logic [RANK_W-1:0] preRank,
  input logic [BANK_W-1:0] preBank,
  input logic [ROW_W-1:0]  preRow,
  input logic              flush,
  input logic              timingValid,
  input logic              lookupHit,
  input logic [TIME_W-1:0] tRcd,
  input logic [TIME_W-1:0] tRas
);
  localparam int TAG_W = RANK_W + BANK_W + ROW_W;
  logic [TAG_W-1:0] aTag;
  logic [TAG_W-1:0] pTag;
  assign aTag = {actRank, actBank, actRow};
  assign pTag = {preRank, preBank, preRow};

  // R2
  act_gives_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    actStrobe |=> timingValid);
  // R2
  idle_gives_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !actStrobe |=> !timingValid);
  // R2
  hit_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> timingValid);
  // R4
  fast_pair_on_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> (tRcd == TIME_W'(FAST_RCD)) && (tRas == TIME_W'(FAST_RAS)));
  // R3
  default_pair_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timingValid && !lookupHit) |-> (tRcd == TIME_W'(DEF_RCD)) && (tRas == TIME_W'(DEF_RAS)));
  // R5
  insert_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (preStrobe && !flush) ##1 (actStrobe && aTag == $past(pTag)) |=> lookupHit);
  // R11
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush ##1 actStrobe |=> !lookupHit);
endmodule

bind charged_row_cache charged_row_cache_chk #(
  .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .TIME_W(TIME_W),
  .DEF_RCD(DEF_RCD), .DEF_RAS(DEF_RAS), .FAST_RCD(FAST_RCD), .FAST_RAS(FAST_RAS)
) u_chk (
  .clk(clk), .rstN(rstN),
  .actStrobe(actStrobe), .actRank(actRank), .actBank(actBank), .actRow(actRow),
  .preStrobe(preStrobe), .preRank(preRank), .preBank(preBank), .preRow(preRow),
  .flush(flush), .timingValid(timingValid), .lookupHit(lookupHit),
  .tRcd(tRcd), .tRas(tRas)
);

// File: tb/charged_row_cache_test.sv
module charged_row_cache_test;
  localparam int RW = 1, BW = 2, ROWW = 6;
  localparam int ENT = 4, AW = 4, PS = 4, TW = 6;
  localparam int TAGW = RW + BW + ROWW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic actStrobe = 1'b0, preStrobe = 1'b0, flush = 1'b0;
  logic [RW-1:0] actRank = '0, preRank = '0;
  logic [BW-1:0] actBank = '0, preBank = '0;
  logic [ROWW-1:0] actRow = '0, preRow = '0;
  logic [AW-1:0] expiryLimit = 4'd15;
  logic timingValid, lookupHit;
  logic [TW-1:0] tRcd, tRas;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  charged_row_cache #(
    .RANK_W(RW), .BANK_W(BW), .ROW_W(ROWW), .ENTRIES(ENT),
    .AGE_W(AW), .PRESCALE(PS), .TIME_W(TW)
  ) uut (.*);

  // Reference model of the requirements
  logic [TAGW-1:0] mTag [ENT];
  bit   mValid [ENT];
  int   mAge [ENT];
  int   mPtr = 0;
  int   mPs = 0;

  function automatic bit mLook(input logic [TAGW-1:0] t);
    for (int i = 0; i < ENT; i++) if (mValid[i] && mTag[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic mUpdate();
    bit tk;
    int m;
    logic [TAGW-1:0] pt;
    pt = {preRank, preBank, preRow};
    tk = (mPs == PS - 1);
    mPs = tk ? 0 : mPs + 1;
    m = -1;
    if (preStrobe) for (int i = 0; i < ENT; i++) if (mValid[i] && mTag[i] == pt) m = i;
    if (flush) begin
      for (int i = 0; i < ENT; i++) mValid[i] = 1'b0;
    end else begin
      if (tk) for (int i = 0; i < ENT; i++)
        if (mValid[i]) begin
          if (mAge[i] + 1 >= int'(expiryLimit)) mValid[i] = 1'b0;
          else mAge[i] = mAge[i] + 1;
        end
      if (preStrobe) begin
        if (m >= 0) begin mValid[m] = 1'b1; mAge[m] = 0; end
        else begin
          mTag[mPtr] = pt; mValid[mPtr] = 1'b1; mAge[mPtr] = 0;
          mPtr = (mPtr + 1) % ENT;
        end
      end
    end
  endtask

  // Drive-then-step: inputs are set at a negedge, checked at the following negedge
  task automatic step(input string req);
    bit eVal, eHit;
    int eRcd, eRas;
    string tag;
    eVal = actStrobe;
    eHit = actStrobe && mLook({actRank, actBank, actRow});
    eRcd = eHit ? 7 : 11;
    eRas = eHit ? 20 : 28;
    tag = (req == "RND") ? (eHit ? "R4" : "R3") : req;
    mUpdate();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (eVal) begin
      if (timingValid !== 1'b1 || lookupHit !== eHit || int'(tRcd) != eRcd || int'(tRas) != eRas) begin
        failures++;
        $display("FAIL %s: valid=%0b hit=%0b rcd=%0d ras=%0d expected valid=1 hit=%0b rcd=%0d ras=%0d",
                 tag, timingValid, lookupHit, tRcd, tRas, eHit, eRcd, eRas);
      end
    end else if (timingValid !== 1'b0 || lookupHit !== 1'b0) begin
      failures++;
      $display("FAIL R2: valid=%0b hit=%0b expected valid=0 hit=0", timingValid, lookupHit);
    end
    actStrobe = 1'b0; preStrobe = 1'b0; flush = 1'b0;
  endtask

  task automatic setPre(input logic [TAGW-1:0] t);
    preStrobe = 1'b1; {preRank, preBank, preRow} = t;
  endtask
  task automatic setAct(input logic [TAGW-1:0] t);
    actStrobe = 1'b1; {actRank, actBank, actRow} = t;
  endtask
  task automatic pre(input logic [TAGW-1:0] t);
    setPre(t); step("R5");
  endtask
  task automatic act(input logic [TAGW-1:0] t, input string req);
    setAct(t); step(req);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("R2");
  endtask
  task automatic expectHit(input bit h, input string req);
    checks++;
    if (lookupHit !== h) begin
      failures++;
      $display("FAIL %s: hit=%0b expected hit=%0b", req, lookupHit, h);
    end
  endtask

  localparam logic [TAGW-1:0] TA = 9'b1_10_010101;
  localparam logic [TAGW-1:0] TB = 9'b0_01_001100;
  localparam logic [TAGW-1:0] TC = 9'b1_00_111000;
  localparam logic [TAGW-1:0] TD = 9'b0_11_000011;
  localparam logic [TAGW-1:0] TE = 9'b1_01_101010;
  localparam logic [TAGW-1:0] TF = 9'b0_00_010001;

  initial begin
    for (int i = 0; i < ENT; i++) begin mValid[i] = 1'b0; mAge[i] = 0; mTag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checks++;
    if (timingValid !== 1'b0 || lookupHit !== 1'b0 || tRcd != 6'd11 || tRas != 6'd28) begin
      failures++;
      $display("FAIL R1: valid=%0b hit=%0b rcd=%0d ras=%0d expected 0 0 11 28",
               timingValid, lookupHit, tRcd, tRas);
    end
    rstN = 1'b1;

    act(TA, "R3");  expectHit(1'b0, "R3");
    pre(TA);
    act(TA, "R4");  expectHit(1'b1, "R5");
    // R6: single-field differences miss
    act(TA ^ 9'b1_00_000000, "R6"); expectHit(1'b0, "R6");
    act(TA ^ 9'b0_01_000000, "R6"); expectHit(1'b0, "R6");
    act(TA ^ 9'b0_00_000001, "R6"); expectHit(1'b0, "R6");
    // R7: same-cycle precharge and activate
    setPre(TB); setAct(TB); step("R7"); expectHit(1'b0, "R7");
    act(TB, "R7"); expectHit(1'b1, "R7");

    // R8 / R9: duplicate re-insert and ring eviction
    flush = 1'b1; step("R11");
    pre(TA); pre(TB); pre(TA); pre(TC); pre(TD); pre(TE);
    act(TA, "R8"); expectHit(1'b0, "R8");
    act(TB, "R9"); expectHit(1'b1, "R9");
    act(TE, "R9"); expectHit(1'b1, "R9");
    pre(TF);
    act(TB, "R9"); expectHit(1'b0, "R9");
    act(TC, "R9"); expectHit(1'b1, "R9");

    // R10: expiry
    flush = 1'b1; step("R11");
    expiryLimit = 4'd3;
    pre(TA);
    act(TA, "R10"); expectHit(1'b1, "R10");
    idle(20);
    act(TA, "R10"); expectHit(1'b0, "R10");
    // R8: re-insert resets age
    pre(TA); idle(6); pre(TA); idle(6);
    act(TA, "R8"); expectHit(1'b1, "R8");

    // R11: flush
    expiryLimit = 4'd15;
    pre(TD);
    flush = 1'b1; setAct(TD); step("R11"); expectHit(1'b1, "R11");
    act(TD, "R11"); expectHit(1'b0, "R11");
    flush = 1'b1; setPre(TC); step("R11");
    act(TC, "R11"); expectHit(1'b0, "R11");

    // Random mix over a small pool
    expiryLimit = 4'd5;
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(99);
      if (r < 50) setAct(TAGW'($urandom_range(5) * 73 + 11));
      if ($urandom_range(99) < 40) setPre(TAGW'($urandom_range(5) * 73 + 11));
      if ($urandom_range(99) < 2) flush = 1'b1;
      step("RND");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule